// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous host port and an asynchronous static RAM that is built from two byte-wide halves. The halves share the address lines and one output-enable strobe. Each half has its own chip-enable and write-enable strobe. The host starts a cycle by raising `req` while `ready` is high. The cycle is a read or a write, chosen by `wr`.

The `byte_mode` input picks the view of the storage for that cycle:
- **Word mode** treats the memory as 2^AW words of 16 bits.
- **Byte mode** treats the same memory as twice as many bytes. Bit 0 of the host address picks the lane, and the bits above it pick the memory word.

Strobe widths and cycle lengths come from nanosecond parameters. Each one is rounded up to whole clock cycles. With the defaults (10 ns clock, 20 ns write pulse, 25 ns write and read cycles):
- the write-enable pulse lasts 2 cycles;
- the read data is sampled 3 cycles after the address and strobes become valid;
- every access keeps `ready` low for 3 cycles.

A drive-enable output tells the pad logic when the controller owns the data bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `ready`=1, `rvalid`=0, `mem_ce_n`=2'b11, `mem_we_n`=2'b11, `mem_oe_n`=1 and `mem_dout_en`=0.
- R2: In word mode, a write holds `mem_addr`=`addr[16:0]`, ignoring `addr[17]`. Both lanes have chip enable and write enable low for exactly 2 cycles, `mem_dout`=`wdata` during the pulse, and `mem_oe_n` stays high for the whole write.
- R3: A request accepted while `ready`=1 drops `ready` in the next cycle. `ready` stays low for 3 cycles for both reads and writes, and it is low whenever any chip enable is low.
- R4: In word mode, a read holds both chip enables and `mem_oe_n` low for 3 cycles, with the write enables high. The returned `rdata` is the full 16-bit word stored at `addr[16:0]`.
- R5: In byte mode, `mem_addr`=`addr[17:1]`. Only one lane has its chip enable low: lane 0 (`mem_ce_n`=2'b10) when `addr[0]`=0, and lane 1 (`mem_ce_n`=2'b01) when `addr[0]`=1. A write enable is never low on a lane whose chip enable is high.
- R6: In byte mode, a write places `wdata[7:0]` on the selected lane's data bits (`mem_dout[7:0]` for lane 0, `mem_dout[15:8]` for lane 1). The other lane's stored byte is unchanged when it is read back.
- R7: In byte mode, a read returns the selected lane's byte in `rdata[7:0]`, with `rdata[15:8]`=0.
- R8: `mem_dout_en` is high only while a write enable is low. It is never high while `mem_oe_n` is low, and it is low in the cycle before `mem_oe_n` falls.
- R9: `rvalid` pulses high for exactly one cycle per read, in the cycle `ready` returns high, and it stays low for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a cycle (taken when ready is high) |
| wr | input | 1 | 1 = write, 0 = read |
| byte_mode | input | 1 | 1 = byte access, 0 = 16-bit word access |
| addr | input | AW+1 | Host address; word mode uses [AW-1:0], byte mode uses [AW:1] plus lane bit [0] |
| wdata | input | DW | Write data; byte mode uses [7:0] |
| ready | output | 1 | Controller idle and able to take a request |
| rvalid | output | 1 | One-cycle read data valid |
| rdata | output | DW | Registered read data |
| mem_addr | output | AW | Memory address lines |
| mem_ce_n | output | 2 | Per-lane chip enables, active low |
| mem_we_n | output | 2 | Per-lane write enables, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dout | output | DW | Data toward memory |
| mem_dout_en | output | 1 | Controller drives the memory data bus |
| mem_din | input | DW | Data from memory |

## Verification
The hardest situation to reach from the ports is lane isolation. A byte write to one lane must leave the other lane's byte intact, and a later word read must combine bytes written separately. Only a mix of byte and word accesses to the same word exposes this.

The random stimulus therefore draws addresses from a small pool, so reads land on previously written words. Directed sequences write both lanes of one word by bytes, read the word back, and then overwrite a single lane. Back-to-back write-then-read sequences exercise the hand-over from bus drive to output enable.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 20,
  parameter int T_WC_NS = 25,
  parameter int T_RC_NS = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic          byte_mode,
  input  logic [AW:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_ce_n,
  output logic [1:0]    mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);
  localparam int BW      = DW / 2;
  localparam int WP_CYC  = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC  = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC  = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int REC_CYC = (WC_CYC > WP_CYC) ? WC_CYC - WP_CYC : 1;
  localparam int MAXC    = (WP_CYC > RD_CYC) ? ((WP_CYC > REC_CYC) ? WP_CYC : REC_CYC)
                                             : ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC);
  localparam int CW      = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WP, S_WREC, S_RD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [1:0]    lane_q;
  logic          bm_q, sel_q;
  logic [DW-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      lane_q <= 2'b00;
      bm_q   <= 1'b0;
      sel_q  <= 1'b0;
      wd_q   <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          cnt    <= '0;
          bm_q   <= byte_mode;
          sel_q  <= addr[0];
          a_q    <= byte_mode ? addr[AW:1] : addr[AW-1:0];
          lane_q <= byte_mode ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;
          wd_q   <= byte_mode ? {2{wdata[BW-1:0]}} : wdata;
          st     <= wr ? S_WP : S_RD;
        end
        S_WP: if (cnt == CW'(WP_CYC - 1)) begin
          cnt <= '0;
          st  <= S_WREC;
        end else cnt <= cnt + 1'b1;
        S_WREC: if (cnt == CW'(REC_CYC - 1)) st <= S_IDLE;
                else cnt <= cnt + 1'b1;
        S_RD: if (cnt == CW'(RD_CYC - 1)) begin
          st     <= S_IDLE;
          rvalid <= 1'b1;
          if (!bm_q)      rdata <= mem_din;
          else if (sel_q) rdata <= {{BW{1'b0}}, mem_din[DW-1:BW]};
          else            rdata <= {{BW{1'b0}}, mem_din[BW-1:0]};
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready       = (st == S_IDLE);
  assign mem_addr    = a_q;
  assign mem_ce_n    = ~(lane_q & {2{st == S_WP || st == S_RD}});
  assign mem_we_n    = ~(lane_q & {2{st == S_WP}});
  assign mem_oe_n    = (st != S_RD);
  assign mem_dout    = wd_q;
  assign mem_dout_en = (st == S_WP);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       rvalid,
  input logic [1:0] mem_ce_n,
  input logic [1:0] mem_we_n,
  input logic       mem_oe_n,
  input logic       mem_dout_en
);
  localparam int WP_CYC = (T_WP_NS + CLK_NS - 1) / CLK_NS;

  logic [7:0] lowcnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                lowcnt <= '0;
    else if (mem_we_n != 2'b11) lowcnt <= lowcnt + 1'b1;
    else                       lowcnt <= '0;
  end

  // R8
  dout_en_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> (mem_we_n != 2'b11));
  // R8
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dout_en && mem_we_n == 2'b11));
  // R8
  oe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dout_en));
  // R5
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n) & mem_ce_n) == 2'b00);
  // R9
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);
  // R3
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n != 2'b11) |-> !ready);
  // R2
  wp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n == 2'b11 && lowcnt != 8'd0) |-> (lowcnt == 8'(WP_CYC)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rvalid(rvalid), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout_en(mem_dout_en));

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, byte_mode = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, rvalid, mem_oe_n, mem_dout_en;
  logic [15:0] rdata, mem_dout, mem_din;
  logic [16:0] mem_addr;
  logic [1:0]  mem_ce_n, mem_we_n;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .byte_mode(byte_mode), .addr(addr),
    .wdata(wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din));

  logic [7:0] m0 [int];
  logic [7:0] m1 [int];
  logic [7:0] r0 [int];
  logic [7:0] r1 [int];

  initial mem_din = 16'hA5A5;
  always @(negedge clk) begin
    if (!mem_ce_n[0] && !mem_we_n[0] && mem_dout_en) m0[int'(mem_addr)] = mem_dout[7:0];
    if (!mem_ce_n[1] && !mem_we_n[1] && mem_dout_en) m1[int'(mem_addr)] = mem_dout[15:8];
    mem_din[7:0]  = (!mem_ce_n[0] && !mem_oe_n && mem_we_n[0])
                    ? (m0.exists(int'(mem_addr)) ? m0[int'(mem_addr)] : 8'h00) : 8'hA5;
    mem_din[15:8] = (!mem_ce_n[1] && !mem_oe_n && mem_we_n[1])
                    ? (m1.exists(int'(mem_addr)) ? m1[int'(mem_addr)] : 8'h00) : 8'hA5;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_addr(input bit bm, input logic [17:0] a);
    return bm ? a[17:1] : a[16:0];
  endfunction

  function automatic logic [1:0] exp_lanes(input bit bm, input logic [17:0] a);
    return bm ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
  endfunction

  function automatic logic [7:0] rbyte(input bit hi, input int w);
    if (hi) return r1.exists(w) ? r1[w] : 8'h00;
    return r0.exists(w) ? r0[w] : 8'h00;
  endfunction

  function automatic logic [15:0] exp_rdata(input bit bm, input logic [17:0] a);
    int w = int'(exp_addr(bm, a));
    if (!bm) return {rbyte(1'b1, w), rbyte(1'b0, w)};
    return {8'h00, rbyte(a[0], w)};
  endfunction

  task automatic run_op(input bit w_r, input bit bm, input logic [17:0] a, input logic [15:0] d);
    int lat = 0, we_cnt = 0, oe_cnt = 0, cont = 0, rv = 0;
    logic [1:0]  ce_seen = 2'b00;
    logic [16:0] a_seen = '0;
    logic [15:0] dsamp = '0;
    logic [15:0] expd = exp_rdata(bm, a);
    int wi = int'(exp_addr(bm, a));
    @(negedge clk);
    req = 1'b1; wr = w_r; byte_mode = bm; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ready && lat < 50) begin
      ce_seen |= ~mem_ce_n;
      if (mem_ce_n != 2'b11) a_seen = mem_addr;
      if (mem_we_n != 2'b11) begin we_cnt++; dsamp = mem_dout; end
      if (!mem_oe_n) begin oe_cnt++; if (mem_dout_en) cont++; end
      if (rvalid) rv++;
      lat++;
      @(negedge clk);
    end
    chk(lat == 3, "R3 busy length", lat, 3);
    chk(ce_seen == exp_lanes(bm, a), bm ? "R5 lane enables" : "R2/R4 lane enables",
        ce_seen, exp_lanes(bm, a));
    chk(a_seen == exp_addr(bm, a), bm ? "R5 memory address" : "R2 memory address",
        a_seen, exp_addr(bm, a));
    chk(cont == 0, "R8 drive during output enable", cont, 0);
    if (w_r) begin
      chk(we_cnt == 2, "R2 write pulse cycles", we_cnt, 2);
      chk(oe_cnt == 0, "R2 output enable during write", oe_cnt, 0);
      chk(rvalid == 1'b0 && rv == 0, "R9 no rvalid on write", rvalid, 0);
      if (!bm) begin
        chk(dsamp == d, "R2 write data", dsamp, d);
        r0[wi] = d[7:0]; r1[wi] = d[15:8];
      end else begin
        chk((a[0] ? dsamp[15:8] : dsamp[7:0]) == d[7:0], "R6 byte steering",
            a[0] ? dsamp[15:8] : dsamp[7:0], d[7:0]);
        if (a[0]) r1[wi] = d[7:0]; else r0[wi] = d[7:0];
      end
    end else begin
      chk(we_cnt == 0 && oe_cnt == 3, "R4 read strobes", oe_cnt, 3);
      chk(rvalid == 1'b1 && rv == 0, "R9 rvalid at ready", rvalid, 1);
      chk(rdata == expd, bm ? "R7 byte read data" : "R4 word read data", rdata, expd);
      @(negedge clk);
      chk(rvalid == 1'b0, "R9 rvalid single cycle", rvalid, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !rvalid && mem_ce_n == 2'b11 && mem_we_n == 2'b11 && mem_oe_n && !mem_dout_en,
        "R1 reset state", {ready, rvalid, mem_ce_n, mem_we_n, mem_oe_n, mem_dout_en}, 8'b10111110);
    // R2 R4: word access at both ends, bit 17 ignored in word mode
    run_op(1'b1, 1'b0, 18'h00000, 16'h1234);
    run_op(1'b0, 1'b0, 18'h20000, 16'h0000);
    run_op(1'b1, 1'b0, 18'h3FFFF, 16'hBEEF);
    run_op(1'b0, 1'b0, 18'h1FFFF, 16'h0000);
    // R5 R6 R7: build one word from two byte writes, then overwrite one lane
    run_op(1'b1, 1'b1, 18'h00100, 16'hFF3C);
    run_op(1'b1, 1'b1, 18'h00101, 16'h00C7);
    run_op(1'b0, 1'b0, 18'h00080, 16'h0000);
    run_op(1'b1, 1'b1, 18'h00101, 16'h5AFF);
    run_op(1'b0, 1'b1, 18'h00100, 16'h0000);
    run_op(1'b0, 1'b1, 18'h00101, 16'h0000);
    run_op(1'b0, 1'b0, 18'h00080, 16'h0000);
    run_op(1'b0, 1'b1, 18'h3FFFF, 16'h0000);
    for (int i = 0; i < 300; i++) begin
      logic [17:0] a;
      a = {1'($urandom), 13'h0000, 4'($urandom)};
      run_op(1'($urandom), 1'($urandom), a, 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule